// File: doc/BRIEF.md
# Matrix LRU Replacement Tracker

This block keeps the exact least-recently-used order of the ways of a single cache set. It is used inside a set-associative cache controller. Every time the controller touches a way of the set (a hit or a fill), it raises an access strobe together with the way number. The block then presents the way that should be replaced next.

The order is held in a square bit matrix with one row and one column per way. An access to way j sets row j to all ones and clears column j to zero, all in the same clock edge. The only row left holding no ones at all belongs to the least recently used way. A zero-row detector turns the matrix into a one-hot victim vector, and an encoder turns that vector into a binary victim index. Both victim outputs are combinational from the stored state.

When the set has two ways, a parameter-selected variant replaces the matrix with a single register that remembers the most recently used way. A synchronous reset and a synchronous clear both reload the start-up order.

Top module: `lru_matrix_tracker`

## Requirements
- R1: After a synchronous reset the order is way WAYS-1 most recent down to way 0 least recent, so the victim index is 0 and the victim vector is 1 in bit 0.
- R2: An access with a way index below WAYS makes that way the most recently used one from the next clock edge on, so it is never the victim right after its access while WAYS is at least 2.
- R3: Across any sequence of accesses, the victim is exactly the way whose most recent access is oldest, with ways never accessed since reset ordered by the start-up order of R1.
- R4: The victim vector always has exactly one bit set, and that bit sits at the position given by the victim index.
- R5: The victim outputs reflect the state before any update taking effect at the coming edge, so an access strobe does not change the victim within its own cycle.
- R6: Asserting the clear input reloads the start-up order of R1 at the next edge and takes priority over an access presented in the same cycle.
- R7: An access whose way index is WAYS or more is ignored, and the victim stays the same.
- R8: In a cycle with neither an access nor a clear, the victim stays the same.
- R9: WAYS must be at least 2 and IDX_W must equal the ceiling of log2(WAYS), both checked at elaboration. With WAYS equal to 2 the victim is always the way other than the last one accessed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on the rising edge |
| rst | input | 1 | Synchronous active-high reset to the start-up order |
| clr_i | input | 1 | Synchronous clear to the start-up order; has priority over an access |
| acc_vld_i | input | 1 | Access strobe for the way given by acc_way_i |
| acc_way_i | input | IDX_W | Index of the accessed way |
| vict_idx_o | output | IDX_W | Binary index of the least recently used way |
| vict_oh_o | output | WAYS | One-hot vector marking the least recently used way |

## Verification
On every cycle the assertions check that the victim vector is one-hot and agrees with the index, and that each matrix row keeps a zero on its diagonal. They also check that a row fills completely when its own way is accessed, that the way just accessed is not the victim, and that the victim stays put across idle cycles and out-of-range accesses. They also check that a clear leaves way 0 as the victim. Only the bench's scenarios can show that the full recency order is exact. For this, the bench compares the victim after every step of directed and random access streams against a most-to-least-recent reference list. The same scenarios show that the victim does not move within the cycle of an access, that a clear wins over a simultaneous access, and that the two-way variant behaves like a single most-recent bit.

// File: rtl/lru_mtx_pkg.sv
package lru_mtx_pkg;
   // Start-up order: row r holds ones in every column below r, giving row r
   // exactly r ones, so row 0 is the only empty row.
   function automatic logic start_bit(input int row, input int col);
      return (col < row);
   endfunction
endpackage

// File: rtl/lru_mtx_row.sv
module lru_mtx_row #(
   parameter int WAYS = 4,
   parameter int ROW  = 0
) (
   input  logic            clk,
   input  logic            rst,
   input  logic            clr_i,
   input  logic [WAYS-1:0] hit_oh_i,
   output logic [WAYS-1:0] row_q_o
);
   import lru_mtx_pkg::*;

   logic [WAYS-1:0] start_row;
   logic [WAYS-1:0] own_full;

   for (genvar c = 0; c < WAYS; c++) begin : g_col
      assign start_row[c] = start_bit(ROW, c);
      assign own_full[c]  = (c != ROW);
   end

   always_ff @(posedge clk) begin
      if (rst || clr_i) begin
         row_q_o <= start_row;
      end else if (hit_oh_i[ROW]) begin
         row_q_o <= own_full;
      end else begin
         row_q_o <= row_q_o & ~hit_oh_i;
      end
   end

   // R3: a way is never more recent than itself
   p_diag_zero_r3: assert property (@(posedge clk) disable iff (rst)
      row_q_o[ROW] == 1'b0);

   // R2: accessing this way marks it more recent than every other way
   p_own_row_full_r2: assert property (@(posedge clk) disable iff (rst)
      (hit_oh_i[ROW] && !clr_i) |=> ($countones(row_q_o) == WAYS-1));
endmodule

// File: rtl/lru_zero_row_pick.sv
module lru_zero_row_pick #(
   parameter int WAYS = 4
) (
   input  logic [WAYS-1:0][WAYS-1:0] mtx_i,
   output logic [WAYS-1:0]           zero_oh_o
);
   for (genvar r = 0; r < WAYS; r++) begin : g_row
      assign zero_oh_o[r] = ~|mtx_i[r];
   end
endmodule

// File: rtl/lru_oh_encode.sv
module lru_oh_encode #(
   parameter int N = 4,
   parameter int W = 2
) (
   input  logic [N-1:0] oh_i,
   output logic [W-1:0] idx_o
);
   always_comb begin
      idx_o = '0;
      for (int i = 0; i < N; i++) begin
         if (oh_i[i]) idx_o = idx_o | W'(i);
      end
   end
endmodule

// File: rtl/lru_matrix_tracker.sv
module lru_matrix_tracker #(
   parameter int WAYS  = 4,
   parameter int IDX_W = $clog2(WAYS)
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             clr_i,
   input  logic             acc_vld_i,
   input  logic [IDX_W-1:0] acc_way_i,
   output logic [IDX_W-1:0] vict_idx_o,
   output logic [WAYS-1:0]  vict_oh_o
);
   // R9: parameter legality
   if (WAYS < 2) begin : g_chk_ways
      $error("lru_matrix_tracker: WAYS must be at least 2");
   end
   if (IDX_W != $clog2(WAYS)) begin : g_chk_idx
      $error("lru_matrix_tracker: IDX_W must equal clog2(WAYS)");
   end

   logic in_range;
   assign in_range = (int'(acc_way_i) < WAYS);

   if (WAYS == 2) begin : g_pair
      // Two ways: one bit naming the most recent way is a full order.
      logic mru_q;
      always_ff @(posedge clk) begin
         if (rst || clr_i) begin
            mru_q <= 1'b1;
         end else if (acc_vld_i) begin
            mru_q <= acc_way_i[0];
         end
      end
      assign vict_idx_o = IDX_W'(~mru_q);
      assign vict_oh_o  = mru_q ? 2'b01 : 2'b10;
   end else begin : g_matrix
      logic [WAYS-1:0]            hit_oh;
      logic [WAYS-1:0][WAYS-1:0]  mtx;

      always_comb begin
         hit_oh = '0;
         if (acc_vld_i && in_range) hit_oh[acc_way_i] = 1'b1;
      end

      for (genvar r = 0; r < WAYS; r++) begin : g_row
         lru_mtx_row #(.WAYS(WAYS), .ROW(r)) row_i (
            .clk      (clk),
            .rst      (rst),
            .clr_i    (clr_i),
            .hit_oh_i (hit_oh),
            .row_q_o  (mtx[r])
         );
      end

      lru_zero_row_pick #(.WAYS(WAYS)) pick_i (
         .mtx_i     (mtx),
         .zero_oh_o (vict_oh_o)
      );

      lru_oh_encode #(.N(WAYS), .W(IDX_W)) enc_i (
         .oh_i  (vict_oh_o),
         .idx_o (vict_idx_o)
      );
   end

   // R4: exactly one victim, agreeing with the index
   p_victim_onehot_r4: assert property (@(posedge clk) disable iff (rst)
      $countones(vict_oh_o) == 1);
   p_idx_matches_oh_r4: assert property (@(posedge clk) disable iff (rst)
      vict_oh_o[vict_idx_o] == 1'b1);

   // R2: the way just accessed is not the next victim
   p_mru_not_victim_r2: assert property (@(posedge clk) disable iff (rst)
      (acc_vld_i && in_range && !clr_i) |=> (vict_idx_o != $past(acc_way_i)));

   // R6: clear restores way 0 as victim
   p_clear_order_r6: assert property (@(posedge clk) disable iff (rst)
      clr_i |=> (vict_idx_o == '0));

   // R7: out-of-range accesses leave the order alone
   p_ignore_oor_r7: assert property (@(posedge clk) disable iff (rst)
      (acc_vld_i && !in_range && !clr_i) |=> $stable(vict_oh_o));

   // R8: idle cycles hold the victim
   p_idle_hold_r8: assert property (@(posedge clk) disable iff (rst)
      (!acc_vld_i && !clr_i) |=> $stable(vict_oh_o));
endmodule

// File: tb/lru_matrix_tracker_tb_top.sv
`timescale 1ns/1ps
module lru_matrix_tracker_tb_top;
   localparam int W  = 6;
   localparam int IW = 3;

   logic clk = 1'b0;
   always #2.5 clk = ~clk;

   logic          rst, clr, vld;
   logic [IW-1:0] way;
   logic [IW-1:0] vidx;
   logic [W-1:0]  voh;
   logic          vld2;
   logic          way2;
   logic          vidx2;
   logic [1:0]    voh2;

   lru_matrix_tracker #(.WAYS(W), .IDX_W(IW)) dut_i (
      .clk(clk), .rst(rst), .clr_i(clr), .acc_vld_i(vld), .acc_way_i(way),
      .vict_idx_o(vidx), .vict_oh_o(voh));

   lru_matrix_tracker #(.WAYS(2), .IDX_W(1)) dut_w2_i (
      .clk(clk), .rst(rst), .clr_i(clr), .acc_vld_i(vld2), .acc_way_i(way2),
      .vict_idx_o(vidx2), .vict_oh_o(voh2));

   int    checks = 0;
   int    fails  = 0;
   int    order[$];
   int    q_exp[$];
   string q_tag[$];
   int    exp2;
   bit    done = 0;

   task automatic chk(string tag, int act, int exp);
      checks++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   task automatic model_reset();
      order = {};
      for (int i = W-1; i >= 0; i--) order.push_back(i);
      exp2 = 0;
   endtask

   // Driver: drive at negedge, check pre-update victim, push expectation.
   task automatic step(bit v, int w, bit c, string tag);
      @(negedge clk);
      vld = v; way = IW'(w); clr = c;
      vld2 = v; way2 = w[0];
      #1;
      chk({"R5 pre-update ", tag}, int'(vidx), order[$]);
      chk({"R4 onehot ", tag}, int'(voh), 1 << order[$]);
      chk({"R9 two-way ", tag}, int'(vidx2), exp2);
      if (c) begin
         model_reset();
      end else if (v) begin
         if (w < W) begin
            foreach (order[i]) if (order[i] == w) begin order.delete(i); break; end
            order.push_front(w);
         end
         exp2 = 1 - (w % 2);
      end
      q_exp.push_back(order[$]);
      q_tag.push_back(tag);
   endtask

   // Monitor: compare after each rising edge.
   initial begin
      forever begin
         @(posedge clk);
         #1;
         if (q_exp.size() > 0) chk(q_tag.pop_front(), int'(vidx), q_exp.pop_front());
      end
   end

   initial begin
      #1000000;
      if (!done) begin
         fails++;
         $display("FAIL watchdog expired");
         $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end

   initial begin
      rst = 1; clr = 0; vld = 0; way = '0; vld2 = 0; way2 = 0;
      model_reset();
      repeat (3) @(negedge clk);
      #1;
      chk("R1 reset victim idx", int'(vidx), 0);
      chk("R1 reset victim oh", int'(voh), 1);
      chk("R1 reset two-way", int'(vidx2), 0);
      rst = 0;
      // R1 order: idle steps keep way 0 victim (R8)
      step(0, 0, 0, "R8 idle");
      step(0, 0, 0, "R8 idle");
      // R2/R3: access 0 then victim becomes 1, etc.
      for (int i = 0; i < W; i++) step(1, i, 0, "R3 ascending");
      for (int i = W-1; i >= 0; i--) step(1, i, 0, "R3 descending");
      step(1, 2, 0, "R2 repeat");
      step(1, 2, 0, "R2 repeat");
      step(1, 4, 0, "R2 single");
      // R7: out-of-range indices ignored
      step(1, 6, 0, "R7 oor6");
      step(1, 7, 0, "R7 oor7");
      step(0, 0, 0, "R8 idle");
      // R6: clear with simultaneous access
      step(1, 0, 1, "R6 clear wins");
      step(0, 0, 0, "R6 after clear");
      step(1, 5, 0, "R3 after clear");
      step(0, 0, 1, "R6 plain clear");
      // R3: random stream including idle, oor and clears
      for (int n = 0; n < 3000; n++) begin
         int r;
         r = int'($urandom_range(0, 99));
         if (r < 2) step(1, int'($urandom_range(0, W-1)), 1, "R6 random clear");
         else if (r < 10) step(0, 0, 0, "R8 random idle");
         else if (r < 15) step(1, int'($urandom_range(W, 7)), 0, "R7 random oor");
         else step(1, int'($urandom_range(0, W-1)), 0, "R3 random");
      end
      step(0, 0, 0, "R8 final idle");
      step(0, 0, 0, "R8 final idle");
      @(negedge clk);
      done = 1;
      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end
endmodule